// File: doc/BRIEF.md
# SPI Serial Memory Slave Interface

This block is the device side of a serial memory reached over SPI in mode 0. A transfer opens when chip select falls. The host then shifts in an 8-bit command, most significant bit first, and for memory commands a 16-bit address. Write data follows the address. For read commands the block returns memory or status bytes on the serial output. The block contains a small byte-addressed array and a status register. Writes into either one are gated by a write-enable latch. Status writes are also gated by a write-protect input combined with a protect-enable bit.

The pins are sampled by a system clock `clk`. Each pin passes through a synchronizer before edge detection. Every SPI phase (clock high, clock low, chip-select setup and hold) must therefore last several `clk` periods. The output is split into a data bit `so` and an enable `so_oe`. A pad wrapper turns these into a three-state pin.

Controller states and transitions:
- **IDLE**: deselected. The *select* transition goes to CMD when chip select is seen low.
- **CMD**: collects the command byte. *decode* goes to ADDR for READ or WRITE, to STAT_RD for RDSR, to STAT_WR for WRSR, and to DONE for WREN or any unknown code.
- **ADDR**: collects the address bytes. *addr_done* goes to READ or WRITE.
- **READ**, **WRITE** and **STAT_RD**: stream bytes until deselect.
- **STAT_WR**: takes one byte. *stat_done* goes to DONE.
- **DONE**: ignores everything else that arrives.
- *deselect*: from any state, a high chip select returns the controller to IDLE.

Top module: `spi_mem_slave`

## Requirements
- R1: While `cs_n` is high, `so_oe` is 0. Serial clock and data activity is ignored, so no command and no write takes effect.
- R2: A transaction begins at the fall of `cs_n`. Its first 8 bits form the command: 0x03 READ, 0x02 WRITE, 0x06 WREN, 0x05 RDSR, 0x01 WRSR. Any other code has no effect.
- R3: `si` is sampled on rising `sck` edges, most significant bit first. This applies to the command, to the two address bytes (the low 9 bits address the 512-byte array), and to data.
- R4: `so` changes only after falling `sck` edges. The first read bit is already valid at the first rising edge that follows the last address bit.
- R5: While `hold_n` is low, `so_oe` is 0 and `sck` and `si` are ignored. Once `hold_n` returns high, the transfer continues from the bit where it stopped.
- R6: READ returns consecutive bytes starting at the given address. The address wraps from 0x1FF to 0x000.
- R7: WRITE stores each complete data byte at consecutive addresses, with the same wrap as R6.
- R8: WREN sets the write-enable latch, which RDSR shows as bit 1. A WRITE or WRSR issued while the latch is clear changes nothing.
- R9: The latch clears when `cs_n` rises after a WRITE or WRSR command byte has been received. This holds even if the write was blocked or aborted.
- R10: RDSR returns the status byte repeatedly. The layout is bit 7 protect-enable, bits 3:2 user bits, bit 1 the latch, and all other bits 0. After reset the status byte is 0x00.
- R11: WRSR updates bits 7, 3 and 2. The update is refused while bit 7 is 1 and `wp_n` is 0.
- R12: A rise of `cs_n` in the middle of a byte drops the partial byte. The next transaction starts again with a command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data from the host |
| hold_n | input | 1 | Pause request, active low |
| wp_n | input | 1 | Write-protect input, active low |
| so | output | 1 | Serial data to the host |
| so_oe | output | 1 | Drive enable for `so` (0 means high impedance) |

## Verification
The assertions assume the following about the host. It holds `sck` low whenever `hold_n` or `cs_n` changes. It keeps `cs_n` low for the whole of a hold. It keeps every SPI phase longer than the synchronizer delay, so that the edges of `sck`, `hold_n` and `cs_n` reach the controller one at a time. The bench keeps to these rules:
- Each `sck` half period is eight system clocks.
- A hold is entered only after `sck` has been low for four clocks.
- While hold is asserted, `sck` is toggled, but it is returned low before `hold_n` is released.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

    localparam logic [7:0] OP_WRSR  = 8'h01;
    localparam logic [7:0] OP_WRITE = 8'h02;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_WREN  = 8'h06;

    // Status byte layout
    localparam int         SR_PEN_BIT = 7;
    localparam int         SR_WEL_BIT = 1;
    localparam logic [7:0] SR_WR_MASK = 8'h8C;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_READ,
        ST_WRITE,
        ST_STAT_RD,
        ST_STAT_WR,
        ST_DONE
    } ctl_state_e;

endpackage

// File: rtl/spi_mem_sync.sv
module spi_mem_sync #(
    parameter int             WIDTH   = 5,
    parameter int             STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_out
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= {STAGES{RST_VAL[g]}};
            end else begin
                chain_q <= {chain_q[STAGES-2:0], pin_in[g]};
            end
        end

        assign pin_out[g] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/spi_mem_store.sv
module spi_mem_store
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W = 9,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_we,
    input  logic [ADDR_W-1:0] mem_waddr,
    input  logic [7:0]        mem_wdata,
    input  logic [ADDR_W-1:0] mem_raddr,
    output logic [7:0]        mem_rdata,
    input  logic              sr_we,
    input  logic [7:0]        sr_wdata,
    input  logic              wp_s,
    output logic [7:0]        sr_bits
);

    logic [7:0] mem_q [DEPTH];
    logic [7:0] sr_q;
    logic       sr_locked;

    always_ff @(posedge clk) begin
        if (mem_we) begin
            mem_q[mem_waddr] <= mem_wdata;
        end
    end

    assign mem_rdata = mem_q[mem_raddr];

    // Protect-enable together with the protect pin freezes the status byte
    assign sr_locked = sr_q[SR_PEN_BIT] && !wp_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (sr_we && !sr_locked) begin
            sr_q <= sr_wdata & SR_WR_MASK;
        end
    end

    assign sr_bits = sr_q;

    // R11: a locked status byte keeps its value
    p_sr_locked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_q[SR_PEN_BIT] && !wp_s) |=> (sr_q == $past(sr_q)));

    // R11: only writable bits ever become set
    p_sr_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sr_we |=> ((sr_q & ~SR_WR_MASK) == 8'h00));

endmodule

// File: rtl/spi_mem_ctl.sv
module spi_mem_ctl
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W = 9,
    localparam int ADDR_BYTES = (ADDR_W + 7) / 8,
    localparam int ASH_W      = ADDR_BYTES * 8,
    localparam int AB_W       = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              cs_rise,
    input  logic              hold_s,
    input  logic              si_s,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic [7:0]        mem_rdata,
    input  logic [7:0]        sr_bits,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [7:0]        mem_wdata,
    output logic [ADDR_W-1:0] mem_raddr,
    output logic              sr_we,
    output logic [7:0]        sr_wdata,
    output logic              so_bit
);

    localparam logic [AB_W-1:0] AB_LAST = AB_W'(ADDR_BYTES - 1);

    ctl_state_e        state_q, state_d;
    logic [2:0]        bit_cnt_q;
    logic [6:0]        rx_sh_q;
    logic [7:0]        tx_sh_q;
    logic [7:0]        cmd_q;
    logic [AB_W-1:0]   abyte_q;
    logic [ASH_W-1:0]  addr_sh_q;
    logic [ADDR_W-1:0] addr_q;
    logic              wel_q;
    logic              wr_ok_q;
    logic              so_q;
    logic              mem_we_q;
    logic [ADDR_W-1:0] mem_waddr_q;
    logic [7:0]        mem_wdata_q;
    logic              sr_we_q;
    logic [7:0]        sr_wdata_q;

    logic              active;
    logic              ev_rise;
    logic              ev_fall;
    logic              byte_done;
    logic [7:0]        rx_byte;
    logic [ASH_W-1:0]  addr_full;
    logic [7:0]        sr_view;
    logic [7:0]        tx_load;

    assign active    = !cs_s && hold_s;
    assign ev_rise   = active && sck_rise;
    assign ev_fall   = active && sck_fall;
    assign byte_done = ev_rise && (bit_cnt_q == 3'd7);
    assign rx_byte   = {rx_sh_q, si_s};
    assign addr_full = (addr_sh_q << 8) | ASH_W'(rx_byte);
    assign sr_view   = sr_bits | (8'(wel_q) << SR_WEL_BIT);
    assign tx_load   = (state_q == ST_READ) ? mem_rdata : sr_view;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!cs_s) state_d = ST_CMD;                       // select
            end
            ST_CMD: begin
                if (byte_done) begin                              // decode
                    case (rx_byte)
                        OP_READ, OP_WRITE: state_d = ST_ADDR;
                        OP_RDSR:           state_d = ST_STAT_RD;
                        OP_WRSR:           state_d = ST_STAT_WR;
                        default:           state_d = ST_DONE;
                    endcase
                end
            end
            ST_ADDR: begin
                if (byte_done && abyte_q == AB_LAST) begin        // addr_done
                    state_d = (cmd_q == OP_READ) ? ST_READ : ST_WRITE;
                end
            end
            ST_STAT_WR: begin
                if (byte_done) state_d = ST_DONE;                 // stat_done
            end
            ST_READ, ST_WRITE, ST_STAT_RD, ST_DONE: begin
                state_d = state_q;
            end
        endcase
        if (cs_s) state_d = ST_IDLE;                              // deselect
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q   <= '0;
            rx_sh_q     <= '0;
            tx_sh_q     <= '0;
            cmd_q       <= '0;
            abyte_q     <= '0;
            addr_sh_q   <= '0;
            addr_q      <= '0;
            wel_q       <= 1'b0;
            wr_ok_q     <= 1'b0;
            so_q        <= 1'b0;
            mem_we_q    <= 1'b0;
            mem_waddr_q <= '0;
            mem_wdata_q <= '0;
            sr_we_q     <= 1'b0;
            sr_wdata_q  <= '0;
        end else begin
            mem_we_q <= 1'b0;
            sr_we_q  <= 1'b0;
            if (cs_s) begin
                bit_cnt_q <= '0;
                abyte_q   <= '0;
                if (cs_rise) begin
                    if (cmd_q == OP_WRITE || cmd_q == OP_WRSR) wel_q <= 1'b0;
                    cmd_q <= '0;
                end
            end else begin
                if (ev_rise) begin
                    bit_cnt_q <= bit_cnt_q + 3'd1;
                    rx_sh_q   <= rx_byte[6:0];
                end
                if (byte_done) begin
                    case (state_q)
                        ST_CMD: begin
                            cmd_q   <= rx_byte;
                            wr_ok_q <= wel_q;
                            if (rx_byte == OP_WREN) wel_q <= 1'b1;
                        end
                        ST_ADDR: begin
                            abyte_q   <= abyte_q + 1'b1;
                            addr_sh_q <= addr_full;
                            if (abyte_q == AB_LAST) addr_q <= addr_full[ADDR_W-1:0];
                        end
                        ST_WRITE: begin
                            mem_we_q    <= wr_ok_q;
                            mem_waddr_q <= addr_q;
                            mem_wdata_q <= rx_byte;
                            addr_q      <= addr_q + 1'b1;
                        end
                        ST_READ: begin
                            addr_q <= addr_q + 1'b1;
                        end
                        ST_STAT_WR: begin
                            sr_we_q    <= wr_ok_q;
                            sr_wdata_q <= rx_byte;
                        end
                        default: begin
                        end
                    endcase
                end
                if (ev_fall && (state_q == ST_READ || state_q == ST_STAT_RD)) begin
                    if (bit_cnt_q == 3'd0) begin
                        so_q    <= tx_load[7];
                        tx_sh_q <= {tx_load[6:0], 1'b0};
                    end else begin
                        so_q    <= tx_sh_q[7];
                        tx_sh_q <= {tx_sh_q[6:0], 1'b0};
                    end
                end
            end
        end
    end

    assign mem_we    = mem_we_q;
    assign mem_waddr = mem_waddr_q;
    assign mem_wdata = mem_wdata_q;
    assign mem_raddr = addr_q;
    assign sr_we     = sr_we_q;
    assign sr_wdata  = sr_wdata_q;
    assign so_bit    = so_q;

    // R1: a deselected device is idle on the following cycle
    p_standby_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> (state_q == ST_IDLE));

    // R5: a held transfer keeps its position and shift contents
    p_hold_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_s && !hold_s) |=> ($stable(bit_cnt_q) && $stable(rx_sh_q)
                                && $stable(tx_sh_q) && $stable(state_q)));

    // R4: output bit moves only after a falling serial clock edge
    p_so_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(so_q) |-> $past(ev_fall));

    // R8: array writes only while the latch is set
    p_write_needs_wel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_q |-> wel_q);

    // R8: status writes only while the latch is set
    p_srwrite_needs_wel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sr_we_q |-> wel_q);

endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W      = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    input  logic hold_n,
    input  logic wp_n,
    output logic so,
    output logic so_oe
);

    localparam int NPIN = 5;
    // pin order: {wp_n, hold_n, si, sck, cs_n}
    localparam logic [NPIN-1:0] PIN_RST = 5'b11001;

    logic [NPIN-1:0]   pins_s;
    logic              cs_s, sck_s, si_s, hold_s, wp_s;
    logic              sck_d, cs_d;
    logic              sck_rise, sck_fall, cs_rise;
    logic              mem_we, sr_we;
    logic [ADDR_W-1:0] mem_waddr, mem_raddr;
    logic [7:0]        mem_wdata, mem_rdata, sr_wdata, sr_bits;
    logic              so_bit;

    spi_mem_sync #(
        .WIDTH   (NPIN),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_RST)
    ) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_in  ({wp_n, hold_n, si, sck, cs_n}),
        .pin_out (pins_s)
    );

    assign cs_s   = pins_s[0];
    assign sck_s  = pins_s[1];
    assign si_s   = pins_s[2];
    assign hold_s = pins_s[3];
    assign wp_s   = pins_s[4];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_d <= 1'b0;
            cs_d  <= 1'b1;
        end else begin
            sck_d <= sck_s;
            cs_d  <= cs_s;
        end
    end

    assign sck_rise = sck_s && !sck_d;
    assign sck_fall = !sck_s && sck_d;
    assign cs_rise  = cs_s && !cs_d;

    spi_mem_ctl #(
        .ADDR_W (ADDR_W)
    ) i_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_s      (cs_s),
        .cs_rise   (cs_rise),
        .hold_s    (hold_s),
        .si_s      (si_s),
        .sck_rise  (sck_rise),
        .sck_fall  (sck_fall),
        .mem_rdata (mem_rdata),
        .sr_bits   (sr_bits),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_wdata (mem_wdata),
        .mem_raddr (mem_raddr),
        .sr_we     (sr_we),
        .sr_wdata  (sr_wdata),
        .so_bit    (so_bit)
    );

    spi_mem_store #(
        .ADDR_W (ADDR_W)
    ) i_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_wdata (mem_wdata),
        .mem_raddr (mem_raddr),
        .mem_rdata (mem_rdata),
        .sr_we     (sr_we),
        .sr_wdata  (sr_wdata),
        .wp_s      (wp_s),
        .sr_bits   (sr_bits)
    );

    assign so    = so_bit;
    assign so_oe = !cs_s && hold_s;

endmodule

// File: tb/test_spi_mem_slave.sv
module test_spi_mem_slave;

    localparam int DEPTH = 512;
    localparam int HALF  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
    logic so, so_oe;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    logic [7:0] ref_mem [DEPTH];
    bit         ref_ok  [DEPTH];

    always #2 clk = ~clk;

    spi_mem_slave i_spi_mem_slave (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (cs_n),
        .sck    (sck),
        .si     (si),
        .hold_n (hold_n),
        .wp_n   (wp_n),
        .so     (so),
        .so_oe  (so_oe)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int pick_hold();
        return (($urandom % 3) == 0) ? int'($urandom % 8) : -1;
    endfunction

    task automatic do_hold();
        wait_clk(4);
        hold_n = 1'b0;
        wait_clk(6);
        chk("R5 output released in hold", 32'(so_oe), 0);
        for (int t = 0; t < 2; t++) begin
            sck = 1'b1; si = ~si; wait_clk(4);
            sck = 1'b0; wait_clk(4);
        end
        hold_n = 1'b1;
        wait_clk(6);
        chk("R5 output driven after hold", 32'(so_oe), 1);
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, input int hold_at);
        for (int i = 7; i >= 0; i--) begin
            if (i == hold_at) do_hold();
            si = tx[i];
            wait_clk(HALF);
            sck = 1'b1;
            rx[i] = so;
            wait_clk(HALF);
            sck = 1'b0;
        end
    endtask

    task automatic cs_begin();
        cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic cs_end();
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(2 * HALF);
    endtask

    task automatic send_cmd(input logic [7:0] op);
        logic [7:0] rx;
        cs_begin();
        xfer(op, rx, -1);
        cs_end();
    endtask

    task automatic send_addr(input logic [7:0] op, input int addr);
        logic [7:0] rx;
        xfer(op, rx, pick_hold());
        xfer(8'((addr >> 8) & 1), rx, -1);
        xfer(8'(addr & 8'hFF), rx, pick_hold());
    endtask

    task automatic write_seq(input int addr, input int n, input bit commit);
        logic [7:0] rx, b;
        cs_begin();
        send_addr(8'h02, addr);
        for (int k = 0; k < n; k++) begin
            b = 8'($urandom);
            xfer(b, rx, pick_hold());
            if (commit) begin
                ref_mem[(addr + k) % DEPTH] = b;
                ref_ok[(addr + k) % DEPTH]  = 1'b1;
            end
        end
        cs_end();
    endtask

    task automatic read_check(input int addr, input int n, input string tag);
        logic [7:0] rx;
        cs_begin();
        send_addr(8'h03, addr);
        for (int k = 0; k < n; k++) begin
            xfer(8'h00, rx, pick_hold());
            if (ref_ok[(addr + k) % DEPTH]) chk(tag, 32'(rx), 32'(ref_mem[(addr + k) % DEPTH]));
        end
        cs_end();
    endtask

    task automatic rdsr_check(input logic [7:0] exp, input string tag);
        logic [7:0] r1, r2;
        cs_begin();
        xfer(8'h05, r1, -1);
        xfer(8'h00, r1, pick_hold());
        xfer(8'h00, r2, -1);
        cs_end();
        chk(tag, 32'(r1), 32'(exp));
        chk({tag, " repeat"}, 32'(r2), 32'(exp));
    endtask

    task automatic wrsr(input logic [7:0] v);
        logic [7:0] rx;
        cs_begin();
        xfer(8'h01, rx, -1);
        xfer(v, rx, pick_hold());
        cs_end();
    endtask

    // R1, R10: state right after reset
    task automatic t_reset();
        chk("R1 so_oe low after reset", 32'(so_oe), 0);
        rdsr_check(8'h00, "R10 status after reset");
    endtask

    // R1: activity while deselected is ignored
    task automatic t_standby();
        logic [7:0] pat;
        pat = 8'h06;
        for (int r = 0; r < 3; r++) begin
            for (int i = 7; i >= 0; i--) begin
                si = pat[i]; wait_clk(HALF);
                sck = 1'b1; wait_clk(HALF);
                sck = 1'b0;
            end
            chk("R1 so_oe low while deselected", 32'(so_oe), 0);
        end
        rdsr_check(8'h00, "R1 latch not set by deselected traffic");
    endtask

    // R2: unknown command has no effect
    task automatic t_bad_opcode();
        logic [7:0] rx;
        cs_begin();
        xfer(8'hAB, rx, -1);
        xfer(8'h06, rx, -1);
        cs_end();
        rdsr_check(8'h00, "R2 unknown opcode ignored");
    endtask

    // R8: a write without the latch is dropped
    task automatic t_no_wel();
        send_cmd(8'h06);
        write_seq(32'h020, 4, 1'b1);
        write_seq(32'h020, 4, 1'b0);
        read_check(32'h020, 4, "R8 write without latch ignored");
    endtask

    // R3, R4, R6, R7, R9 with random hold pulses (R5)
    task automatic t_basic();
        send_cmd(8'h06);
        rdsr_check(8'h02, "R8 R10 latch visible");
        write_seq(32'h100, 16, 1'b1);
        rdsr_check(8'h00, "R9 latch cleared after write");
        read_check(32'h100, 16, "R3 R4 R6 R7 read back");
    endtask

    // R6, R7: address wrap
    task automatic t_wrap();
        send_cmd(8'h06);
        write_seq(32'h1FD, 6, 1'b1);
        read_check(32'h1FE, 4, "R6 R7 wrap at top");
    endtask

    // R11: protection of the status byte
    task automatic t_status();
        send_cmd(8'h06);
        wrsr(8'hFF);
        rdsr_check(8'h8C, "R11 writable bits only");
        wp_n = 1'b0;
        send_cmd(8'h06);
        wrsr(8'h00);
        rdsr_check(8'h8C, "R11 blocked and R9 latch cleared");
        wp_n = 1'b1;
        send_cmd(8'h06);
        wrsr(8'h00);
        rdsr_check(8'h00, "R11 unlocked write");
        wrsr(8'h84);
        rdsr_check(8'h00, "R8 status write without latch");
        wp_n = 1'b0;
        send_cmd(8'h06);
        wrsr(8'h0C);
        rdsr_check(8'h0C, "R11 pin alone does not block");
        wp_n = 1'b1;
        send_cmd(8'h06);
        wrsr(8'h00);
        rdsr_check(8'h00, "R11 cleared again");
    endtask

    // R12: abort mid-byte
    task automatic t_abort();
        logic [7:0] rx;
        send_cmd(8'h06);
        write_seq(32'h041, 1, 1'b1);
        send_cmd(8'h06);
        cs_begin();
        send_addr(8'h02, 32'h040);
        xfer(8'h5A, rx, -1);
        ref_mem[32'h040] = 8'h5A;
        ref_ok[32'h040]  = 1'b1;
        for (int i = 0; i < 4; i++) begin
            si = 1'b1; wait_clk(HALF);
            sck = 1'b1; wait_clk(HALF);
            sck = 1'b0;
        end
        cs_end();
        read_check(32'h040, 2, "R12 partial byte dropped");
        rdsr_check(8'h00, "R9 R12 latch cleared after abort");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < DEPTH; a++) ref_ok[a] = 1'b0;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        t_reset();
        t_standby();
        t_bad_opcode();
        t_no_wel();
        t_basic();
        t_wrap();
        t_status();
        t_abort();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule